// File: doc/BRIEF.md
# DRAM Command Timing Gate

This block sits between a DRAM command scheduler and the memory pins. Each cycle the scheduler presents one proposed command, which is ACTIVATE, READ, WRITE, PRECHARGE, MODE-REGISTER-SET or a no-operation, together with a bank number. The block answers in the same cycle whether that command may go out without breaking any DRAM timing rule. When the scheduler actually sends a command, it pulses the issue strobe and the block updates its timers.

The timers come in two kinds. Per-bank timers enforce ACTIVATE-to-ACTIVATE, ACTIVATE-to-column, ACTIVATE-to-PRECHARGE, READ-to-PRECHARGE and PRECHARGE-to-ACTIVATE spacing. Global timers enforce cross-bank ACTIVATE spacing, column-command turnarounds and mode-register spacing. A history of the last four ACTIVATE ages enforces a rolling four-activate window. All limits are decoded from two packed 32-bit timing words, some of them with small offset encodings.

If a command is issued while it is not legal, a sticky violation flag is set. The command still loads the timers, because it has reached the pins. Reset is asynchronous and active low.

Top module: `dram_cmd_timing_gate`

## Requirements
- R1: After reset every command code is reported legal on `cmd_ok` and `violation` is low.
- R2: ACTIVATE (code 1) to a bank is legal only when at least tRC clocks have passed since the last ACTIVATE to that bank (word A bits 30:25) and at least tRP clocks since the last PRECHARGE to it (word A bits 11:8).
- R3: ACTIVATE is legal only when at least tRRD clocks have passed since the last ACTIVATE to any bank (word A bits 24:21).
- R4: ACTIVATE is legal only when the fourth most recent ACTIVATE lies at least tFAW clocks in the past (word B bits 8:3).
- R5: READ (code 2) and WRITE (code 3) to a bank need at least tRCD clocks since that bank's last ACTIVATE (word A bits 15:12).
- R6: The column spacing rules are as follows. Between two READs, or between two WRITEs, the spacing is tCCD = 4 + word A bit 31. A WRITE after a READ needs tCCD + 2 + word B bit 2. A READ after a WRITE needs 4 + tWTR (word A bits 7:5), where 4 is the burst length in clocks.
- R7: PRECHARGE (code 4) to a bank needs tRAS clocks since that bank's last ACTIVATE (word A bits 20:16) and tRTP clocks since its last READ (word A bits 4:2).
- R8: MODE-REGISTER-SET (code 5) needs 4 + word A bits 1:0 clocks since the previous one. ACTIVATE, READ, WRITE and PRECHARGE need 12 + word B bits 10:9 clocks since the last one.
- R9: Codes 0, 6 and 7 are no-operations. They are always legal, and issuing one changes no timer.
- R10: Issuing a command while `cmd_ok` is low sets `violation` one cycle later, and it stays set until reset. The illegal command still loads the timers, and `cmd_ok` never depends on `issue`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timing_a | input | 32 | Packed timing word A (bank and column timings, tCCD, tMRD) |
| timing_b | input | 32 | Packed timing word B (tFAW, tMOD, read-to-write extra clock) |
| prop_cmd | input | 3 | Proposed command code |
| prop_bank | input | 3 | Bank of the proposed command |
| issue | input | 1 | The proposed command is sent this cycle |
| cmd_ok | output | 1 | The proposed command is legal this cycle |
| violation | output | 1 | Sticky flag: an illegal command was issued |

## Verification
`cmd_ok` is combinational from the timer state, so the bench compares it in the same cycle the command is proposed, 1 ns after the falling edge. A command issued at rising edge T affects legality from edge T+1, and its spacing rule X means that the command is legal at edge T+X. The bench model keeps issue timestamps and tests `now - T >= X`. This follows a different route from the counters in the design. `violation` is due one cycle after an illegal issue and is compared at the next falling edge. Directed polls count the exact number of illegal cycles for the four-activate window, the mode-register spacing and the post-MRS lockout.

// File: rtl/dram_cmd_timing_gate.sv
module dram_cmd_timing_gate #(
  parameter int BANKS       = 8,
  parameter int BURST_CLKS  = 4,
  parameter int CNT_W       = 6,
  parameter int FAW_ENTRIES = 4,
  localparam int BANK_W     = $clog2(BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       timing_a,
  input  logic [31:0]       timing_b,
  input  logic [2:0]        prop_cmd,
  input  logic [BANK_W-1:0] prop_bank,
  input  logic              issue,
  output logic              cmd_ok,
  output logic              violation
);
  localparam logic [2:0] C_ACT = 3'd1, C_RD = 3'd2, C_WR = 3'd3, C_PRE = 3'd4, C_MRS = 3'd5;
  typedef logic [CNT_W-1:0] cnt_t;

  cnt_t t_ccd, t_rc, t_rrd, t_ras, t_rcd, t_rp, t_wtr, t_rtp, t_mrd, t_faw, t_mod, t_rtw;
  assign t_ccd = CNT_W'(4) + CNT_W'(timing_a[31]);
  assign t_rc  = CNT_W'(timing_a[30:25]);
  assign t_rrd = CNT_W'(timing_a[24:21]);
  assign t_ras = CNT_W'(timing_a[20:16]);
  assign t_rcd = CNT_W'(timing_a[15:12]);
  assign t_rp  = CNT_W'(timing_a[11:8]);
  assign t_wtr = CNT_W'(BURST_CLKS) + CNT_W'(timing_a[7:5]);
  assign t_rtp = CNT_W'(timing_a[4:2]);
  assign t_mrd = CNT_W'(4) + CNT_W'(timing_a[1:0]);
  assign t_faw = CNT_W'(timing_b[8:3]);
  assign t_mod = CNT_W'(12) + CNT_W'(timing_b[10:9]);
  assign t_rtw = t_ccd + CNT_W'(2) + CNT_W'(timing_b[2]);

  function automatic cnt_t dec(cnt_t v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  function automatic cnt_t ld(cnt_t cur, cnt_t lim);
    cnt_t d = dec(cur);
    cnt_t n = dec(lim);
    return (d > n) ? d : n;
  endfunction

  function automatic cnt_t inc(cnt_t v);
    return (v == '1) ? v : v + 1'b1;
  endfunction

  cnt_t act_w [BANKS];
  cnt_t col_w [BANKS];
  cnt_t pre_w [BANKS];
  cnt_t faw_age [FAW_ENTRIES];
  cnt_t act_g, rd_g, wr_g, mrs_g, mod_g;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < BANKS; b++) begin
        act_w[b] <= '0;
        col_w[b] <= '0;
        pre_w[b] <= '0;
      end
      for (int i = 0; i < FAW_ENTRIES; i++) faw_age[i] <= '1;
      act_g <= '0; rd_g <= '0; wr_g <= '0; mrs_g <= '0; mod_g <= '0;
      violation <= 1'b0;
    end else begin
      for (int b = 0; b < BANKS; b++) begin
        act_w[b] <= dec(act_w[b]);
        col_w[b] <= dec(col_w[b]);
        pre_w[b] <= dec(pre_w[b]);
      end
      for (int i = 0; i < FAW_ENTRIES; i++) faw_age[i] <= inc(faw_age[i]);
      act_g <= dec(act_g); rd_g <= dec(rd_g); wr_g <= dec(wr_g);
      mrs_g <= dec(mrs_g); mod_g <= dec(mod_g);
      if (issue && !cmd_ok) violation <= 1'b1;
      if (issue) begin
        case (prop_cmd)
          C_ACT: begin
            act_w[prop_bank] <= ld(act_w[prop_bank], t_rc);
            col_w[prop_bank] <= ld(col_w[prop_bank], t_rcd);
            pre_w[prop_bank] <= ld(pre_w[prop_bank], t_ras);
            act_g <= ld(act_g, t_rrd);
            faw_age[0] <= CNT_W'(1);
            for (int i = 1; i < FAW_ENTRIES; i++) faw_age[i] <= inc(faw_age[i-1]);
          end
          C_RD: begin
            rd_g <= ld(rd_g, t_ccd);
            wr_g <= ld(wr_g, t_rtw);
            pre_w[prop_bank] <= ld(pre_w[prop_bank], t_rtp);
          end
          C_WR: begin
            wr_g <= ld(wr_g, t_ccd);
            rd_g <= ld(rd_g, t_wtr);
          end
          C_PRE: act_w[prop_bank] <= ld(act_w[prop_bank], t_rp);
          C_MRS: begin
            mrs_g <= ld(mrs_g, t_mrd);
            mod_g <= ld(mod_g, t_mod);
          end
          default: ;
        endcase
      end
    end
  end

  logic no_mod;
  assign no_mod = (mod_g == '0);

  always_comb begin
    case (prop_cmd)
      C_ACT:   cmd_ok = (act_w[prop_bank] == '0) && (act_g == '0) && no_mod &&
                        (faw_age[FAW_ENTRIES-1] >= t_faw);
      C_RD:    cmd_ok = (col_w[prop_bank] == '0) && (rd_g == '0) && no_mod;
      C_WR:    cmd_ok = (col_w[prop_bank] == '0) && (wr_g == '0) && no_mod;
      C_PRE:   cmd_ok = (pre_w[prop_bank] == '0) && no_mod;
      C_MRS:   cmd_ok = (mrs_g == '0);
      default: cmd_ok = 1'b1;
    endcase
  end
endmodule

// File: rtl/dram_cmd_timing_gate_chk.sv
module dram_cmd_timing_gate_chk #(
  parameter int BANKS   = 8,
  localparam int BANK_W = $clog2(BANKS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [31:0]       timing_a,
  input logic [31:0]       timing_b,
  input logic [2:0]        prop_cmd,
  input logic [BANK_W-1:0] prop_bank,
  input logic              issue,
  input logic              cmd_ok,
  input logic              violation
);
  // R10
  violation_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    violation |=> violation);
  // R10
  illegal_issue_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !cmd_ok) |=> violation);
  // R3
  rrd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && prop_cmd == 3'd1 && timing_a[24:21] >= 4'd2) |=> !(prop_cmd == 3'd1 && cmd_ok));
  // R6
  ccd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && prop_cmd == 3'd2) |=> !(prop_cmd == 3'd2 && cmd_ok));
  // R8
  mod_lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && prop_cmd == 3'd5) |=> !(cmd_ok && prop_cmd inside {3'd1, 3'd2, 3'd3, 3'd4}));
  // R9
  nop_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prop_cmd inside {3'd0, 3'd6, 3'd7}) |-> cmd_ok);
endmodule

bind dram_cmd_timing_gate dram_cmd_timing_gate_chk #(.BANKS(BANKS)) u_chk (.*);

// File: tb/test_dram_cmd_timing_gate.sv
module test_dram_cmd_timing_gate;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] timing_a = '0, timing_b = '0;
  logic [2:0] prop_cmd = '0, prop_bank = '0;
  logic issue = 1'b0;
  logic cmd_ok, violation;

  dram_cmd_timing_gate i_dram_cmd_timing_gate (.*);

  always #2 clk = ~clk;

  int checks = 0, failures = 0;
  longint cyc = 0;
  longint last_act[8], last_pre[8], last_rd[8], g_act, g_rd, g_wr, g_mrs;
  longint faw_h[4];
  bit viol_m;
  int tccd, trc, trrd, tras, trcd, trp, twtr, trtp, tmrd, tfaw, tmod, trtw;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d cycle=%0d", tag, act, exp, cyc);
    end
  endtask

  task automatic set_timing(input logic [31:0] a, input logic [31:0] b);
    timing_a = a; timing_b = b;
    tccd = 4 + a[31]; trc = a[30:25]; trrd = a[24:21]; tras = a[20:16];
    trcd = a[15:12]; trp = a[11:8]; twtr = 4 + a[7:5]; trtp = a[4:2];
    tmrd = 4 + a[1:0]; tfaw = b[8:3]; tmod = 12 + b[10:9]; trtw = tccd + 2 + b[2];
  endtask

  function automatic bit exp_ok(int c, int b);
    bit m = (cyc - g_mrs) >= tmod;
    case (c)
      1: return (cyc-last_act[b] >= trc) && (cyc-last_pre[b] >= trp) && (cyc-g_act >= trrd)
                && (cyc-faw_h[3] >= tfaw) && m;
      2: return (cyc-last_act[b] >= trcd) && (cyc-g_rd >= tccd) && (cyc-g_wr >= twtr) && m;
      3: return (cyc-last_act[b] >= trcd) && (cyc-g_wr >= tccd) && (cyc-g_rd >= trtw) && m;
      4: return (cyc-last_act[b] >= tras) && (cyc-last_rd[b] >= trtp) && m;
      5: return (cyc-g_mrs) >= tmrd;
      default: return 1'b1;
    endcase
  endfunction

  function automatic string tag_of(int c);
    case (c)
      1: return "R2 R3 R4 R8";
      2, 3: return "R5 R6 R8";
      4: return "R7 R8";
      5: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic record(int c, int b);
    case (c)
      1: begin
        last_act[b] = cyc; g_act = cyc;
        for (int i = 3; i > 0; i--) faw_h[i] = faw_h[i-1];
        faw_h[0] = cyc;
      end
      2: begin g_rd = cyc; last_rd[b] = cyc; end
      3: g_wr = cyc;
      4: last_pre[b] = cyc;
      5: g_mrs = cyc;
      default: ;
    endcase
  endtask

  // mode 0: never issue, 1: issue when legal, 2: always issue
  task automatic step(input int c, input int b, input int mode, output bit seen);
    bit e, iss;
    @(negedge clk);
    e = exp_ok(c, b);
    iss = (mode == 2) || (mode == 1 && e);
    prop_cmd = 3'(c); prop_bank = 3'(b); issue = iss;
    #1;
    seen = cmd_ok;
    check(cmd_ok == e, tag_of(c), cmd_ok, e);
    check(violation == viol_m, "R10", violation, viol_m);
    @(posedge clk);
    if (iss) begin
      if (!e) viol_m = 1'b1;
      record(c, b);
    end
    cyc++;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; issue = 1'b0; prop_cmd = '0;
    repeat (2) @(posedge clk);
    cyc += 2;
    @(negedge clk);
    rst_n = 1'b1;
    for (int b = 0; b < 8; b++) begin
      last_act[b] = cyc - 1000; last_pre[b] = cyc - 1000; last_rd[b] = cyc - 1000;
    end
    for (int i = 0; i < 4; i++) faw_h[i] = cyc - 1000;
    g_act = cyc - 1000; g_rd = cyc - 1000; g_wr = cyc - 1000; g_mrs = cyc - 1000;
    viol_m = 1'b0;
  endtask

  function automatic logic [31:0] mk_a(int ccd, int rc, int rrd, int ras, int rcd, int rp,
                                       int wtr, int rtp, int mrd);
    return {1'(ccd), 6'(rc), 4'(rrd), 5'(ras), 4'(rcd), 4'(rp), 3'(wtr), 3'(rtp), 2'(mrd)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit s;
    int n;
    void'($urandom(32'd20240611));
    set_timing(mk_a(0, 10, 3, 7, 3, 3, 2, 2, 1), 32'd16 << 3);
    do_reset();
    // R1: reset state
    for (int c = 0; c < 8; c++) begin
      prop_cmd = 3'(c);
      #1;
      check(cmd_ok == 1'b1, "R1", cmd_ok, 1);
    end
    check(violation == 1'b0, "R1", violation, 0);

    // R4: four ACTs at consecutive cycles, the fifth waits for tFAW=20
    set_timing(mk_a(0, 2, 1, 2, 1, 1, 0, 1, 0), 32'd20 << 3);
    do_reset();
    for (int b = 0; b < 4; b++) step(1, b, 1, s);
    n = 0;
    step(1, 4, 1, s);
    while (!s && n < 100) begin n++; step(1, 4, 1, s); end
    check(n == 16, "R4", n, 16);

    // R8: MRS spacing 4+3=7, then lockout 12+2=14 for READ
    set_timing(mk_a(0, 2, 1, 2, 1, 1, 0, 1, 3), 32'd2 << 9);
    do_reset();
    step(5, 0, 1, s);
    n = 0;
    step(5, 0, 0, s);
    while (!s && n < 100) begin n++; step(5, 0, 0, s); end
    check(n == 6, "R8", n, 6);
    while (!s && n < 100) ;
    n = 1 + n;
    step(2, 0, 0, s);
    while (!s && n < 100) begin n++; step(2, 0, 0, s); end
    check(n == 13, "R8", n, 13);

    // R6: READ then WRITE with tCCD=5 and the extra turnaround clock: 5+2+1=8
    set_timing(mk_a(1, 2, 1, 2, 1, 1, 0, 1, 0), 32'd1 << 2);
    do_reset();
    step(1, 2, 1, s);
    step(2, 2, 1, s);
    n = 0;
    step(3, 2, 0, s);
    while (!s && n < 100) begin n++; step(3, 2, 0, s); end
    check(n == 7, "R6", n, 7);

    // R9 and R10: NOP issue leaves timers, illegal issue sets sticky flag
    step(0, 1, 2, s);
    step(6, 1, 2, s);
    step(2, 2, 2, s);
    step(2, 2, 2, s);
    step(0, 0, 0, s);
    step(0, 0, 0, s);

    // random phases
    for (int ph = 0; ph < 12; ph++) begin
      logic [31:0] a, b;
      a = $urandom;
      b = $urandom;
      if (ph % 2 == 0) begin
        a[30:25] = 6'($urandom_range(0, 12));
        b[8:3] = 6'($urandom_range(0, 24));
      end
      set_timing(a, b);
      do_reset();
      for (int k = 0; k < 3000; k++) begin
        int c, bk, r, md;
        r = $urandom_range(0, 99);
        c = $urandom_range(0, 7);
        bk = $urandom_range(0, 7);
        md = (r < 2) ? 2 : ((r < 75) ? 1 : 0);
        step(c, bk, md, s);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule